// File: doc/BRIEF.md
# Timer Clock Prescaler with Ratio Select

This block derives a count-enable strobe for an 8-bit timer from the single clock that drives the timer. A 3-bit ratio code picks one of three behaviours. The timer can be stopped. It can count on every clock. It can count once per 8, 32, 64, 128, 256 or 1024 clocks. The divided ratios all come from one shared 10-bit free-running count, and each ratio's strobe is taken from a wrap of a low slice of that count. Changing the code does not restart the count, so a new ratio takes effect at its next natural wrap.

Software can ask for the shared count to be cleared, so that the next divided strobe arrives a known number of clocks later. It does this by pulsing a clear-request input. The request bit is visible on an output. It normally drops by itself one clock after the count has been cleared. While a hold input is high, the request bit stays up and the divided count stays pinned at zero, so several timers can be released together.

Top module: `tmr_prescale`

## Requirements
- R1: While reset is asserted, the strobe output and the request status output are both 0.
- R2: With ratio code 3'b000, the strobe stays 0 on every clock.
- R3: With ratio code 3'b001, the strobe is 1 at every clock edge that follows a cycle in which that code was applied. This holds even while a clear request is pending.
- R4: Codes 3'b010, 3'b011, 3'b100, 3'b101, 3'b110 and 3'b111 select division by 8, 32, 64, 128, 256 and 1024 respectively. Each strobe lasts exactly one clock, and strobes repeat every N clocks.
- R5: A pulse on the clear-request input makes the status output 1 after the next clock edge. With hold low and no new pulse, the status returns to 0 one edge later.
- R6: While the status is 1 the shared count is forced to zero. The first divided strobe after the status falls comes exactly N clock edges after the edge at which it falls.
- R7: While hold is 1 the status stays 1, and no divided strobe is produced. After hold drops, the status clears at the next edge.
- R8: A change of ratio code leaves the shared count running. The new ratio's first strobe follows the next wrap of its own slice of the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 3 | Ratio code: 0 stop, 1 undivided, 2..7 divided |
| clr_req_wr | input | 1 | One-clock pulse requesting a clear of the shared count |
| sync_hold | input | 1 | Keeps the request pending and the count pinned at zero |
| cnt_tick | output | 1 | One-clock count-enable strobe for the timer |
| clr_req_q | output | 1 | Pending clear-request status bit |

## Verification
Both outputs are registered, so the strobe and the status bit are each due at the first clock edge after the inputs that cause them. After a clear, the first divided strobe is due N edges after the edge where the status falls. For every cycle, the driver computes the expected strobe and status from a behavioural model of the requirements and queues them before that edge. The monitor pops one entry per edge and compares it 2 ns after the edge, so a strobe arriving one cycle early or late shows up as a mismatch.

// File: rtl/tmr_prescale_pkg.sv
package tmr_prescale_pkg;
   localparam int unsigned SEL_W    = 3;
   localparam int unsigned NUM_TAPS = 6;
   // log2 of each divided ratio, indexed by (code - 2)
   localparam int unsigned TAP_LOG2 [NUM_TAPS] = '{3, 5, 6, 7, 8, 10};
   localparam int unsigned MAX_TAP_LOG2 = 10;

   typedef enum logic [SEL_W-1:0] {
      SEL_STOP  = 3'd0,
      SEL_DIV1  = 3'd1
   } sel_fixed_e;
endpackage

// File: rtl/psc_req_ctrl.sv
module psc_req_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic hold,
   output logic req_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= set_req | (req_q & hold);
   end
endmodule

// File: rtl/psc_counter.sv
module psc_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clear) cnt <= '0;
      else            cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/psc_tap_select.sv
module psc_tap_select
   import tmr_prescale_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEL_W-1:0] sel,
   input  logic             req,
   output logic             tick
);
   logic [NUM_TAPS-1:0] wrap;
   logic [SEL_W-1:0]    tap_idx;
   logic                tick_d;

   for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
      localparam int unsigned LW = TAP_LOG2[i];
      assign wrap[i] = &cnt[LW-1:0];
   end

   assign tap_idx = sel - SEL_W'(2);

   always_comb begin
      tick_d = 1'b0;
      if (sel == SEL_DIV1)
         tick_d = 1'b1;
      else if (sel != SEL_STOP && !req)
         tick_d = wrap[tap_idx];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick <= 1'b0;
      else        tick <= tick_d;
   end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
   import tmr_prescale_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] ratio_sel,
   input  logic             clr_req_wr,
   input  logic             sync_hold,
   output logic             cnt_tick,
   output logic             clr_req_q
);
   if (CNT_W < MAX_TAP_LOG2) begin : g_bad_width
      $error("tmr_prescale: CNT_W too small for the largest ratio");
   end

   logic [CNT_W-1:0] pre_cnt;

   psc_req_ctrl u_req (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_req(clr_req_wr),
      .hold   (sync_hold),
      .req_q  (clr_req_q)
   );

   psc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .clear(clr_req_q),
      .cnt  (pre_cnt)
   );

   psc_tap_select #(.CNT_W(CNT_W)) u_tap (
      .clk  (clk),
      .rst_n(rst_n),
      .cnt  (pre_cnt),
      .sel  (ratio_sel),
      .req  (clr_req_q),
      .tick (cnt_tick)
   );
endmodule

// File: rtl/tmr_prescale_chk.sv
module tmr_prescale_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] ratio_sel,
   input logic       clr_req_wr,
   input logic       sync_hold,
   input logic       cnt_tick,
   input logic       clr_req_q
);
   always @(negedge clk) begin
      if (!rst_n) assert_reset_quiet_R1: assert (!cnt_tick && !clr_req_q);
   end

   assert_stop_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_sel == 3'd0 |=> !cnt_tick);

   assert_undiv_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_sel == 3'd1 |=> cnt_tick);

   assert_single_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick && ratio_sel >= 3'd2 && $past(ratio_sel) >= 3'd2) |=> !cnt_tick);

   assert_req_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req_wr |=> clr_req_q);

   assert_req_selfclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req_q && !sync_hold && !clr_req_wr) |=> !clr_req_q);

   assert_hold_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req_q && sync_hold) |=> clr_req_q);

   assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req_q && ratio_sel >= 3'd2) |=> !cnt_tick);
endmodule

bind tmr_prescale tmr_prescale_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ratio_sel (ratio_sel),
   .clr_req_wr(clr_req_wr),
   .sync_hold (sync_hold),
   .cnt_tick  (cnt_tick),
   .clr_req_q (clr_req_q)
);

// File: tb/test_tmr_prescale.sv
module test_tmr_prescale;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] ratio_sel = 3'd0;
   logic       clr_req_wr = 1'b0;
   logic       sync_hold = 1'b0;
   logic       cnt_tick;
   logic       clr_req_q;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic  tk;
      logic  rq;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   int ref_cnt = 0;
   logic ref_req = 1'b0;

   always #5 clk = ~clk;

   tmr_prescale i_tmr_prescale (
      .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel),
      .clr_req_wr(clr_req_wr), .sync_hold(sync_hold),
      .cnt_tick(cnt_tick), .clr_req_q(clr_req_q)
   );

   function automatic int ratio_of(input logic [2:0] s);
      case (s)
         3'd2: return 8;
         3'd3: return 32;
         3'd4: return 64;
         3'd5: return 128;
         3'd6: return 256;
         3'd7: return 1024;
         default: return 0;
      endcase
   endfunction

   // driver: called at a falling edge, applies inputs and queues the
   // outputs expected after the next rising edge
   task automatic step(input logic [2:0] s, input logic wr, input logic hd,
                       input string tag);
      exp_t e;
      int n;
      ratio_sel = s; clr_req_wr = wr; sync_hold = hd;
      n = ratio_of(s);
      e.tk = (s == 3'd1) || (n != 0 && !ref_req && (ref_cnt % n) == n - 1);
      e.rq = wr || (ref_req && hd);
      e.tag = tag;
      ref_cnt = ref_req ? 0 : (ref_cnt + 1) % 1024;
      ref_req = e.rq;
      exp_q.push_back(e);
      @(negedge clk);
   endtask

   task automatic run(input logic [2:0] s, input int n, input string tag);
      for (int i = 0; i < n; i++) step(s, 1'b0, 1'b0, tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cnt_tick !== e.tk) begin
               errors++;
               $display("FAIL %s tick: actual %b expected %b", e.tag, cnt_tick, e.tk);
            end
            checks++;
            if (clr_req_q !== e.rq) begin
               errors++;
               $display("FAIL %s req: actual %b expected %b", e.tag, clr_req_q, e.rq);
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      checks++;
      if (cnt_tick !== 1'b0 || clr_req_q !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: actual %b%b expected 00", cnt_tick, clr_req_q);
      end
      rst_n = 1'b1;
      run(3'd0, 40, "R2");
      run(3'd1, 20, "R3");
      run(3'd2, 20, "R4");
      // R5/R6: clear request while dividing by 8
      step(3'd2, 1'b1, 1'b0, "R5");
      run(3'd2, 30, "R6");
      for (int c = 3; c <= 7; c++) run(3'(c), 2 * ratio_of(3'(c)) + 5, "R4");
      // R7: request held
      step(3'd2, 1'b1, 1'b1, "R7");
      for (int i = 0; i < 25; i++) step(3'd2, 1'b0, 1'b1, "R7");
      run(3'd2, 30, "R7");
      // R8: ratio change mid-count
      run(3'd3, 13, "R8");
      run(3'd2, 40, "R8");
      run(3'd4, 80, "R8");
      // R3 undivided ignores pending request
      step(3'd1, 1'b1, 1'b1, "R3");
      for (int i = 0; i < 10; i++) step(3'd1, 1'b0, 1'b1, "R3");
      run(3'd1, 5, "R3");
      run(3'd2, 20, "R6");
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule